// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block decides the operating mode of a digital phase-locked loop that
tracks one of three timing references. It watches a qualification flag per
reference, reported by reference monitors that sit outside the block. It also
watches a phase-lock indication from the loop. From these it moves the loop
through four modes: free-run, lock acquisition, normal (locked) and holdover.
It names the reference the loop must follow. It emits single-cycle strobes
that tell the loop filter to freeze its stored frequency word on entry into
holdover and to release it on exit.

Software or board logic can take over at any time with a manual enable. While
the enable is high, the mode and the reference index come straight from the
manual inputs. When the enable drops, the automatic machine carries on from
whatever state was forced. All pins are plain level control and status. No
data stream crosses the block, so it has no handshake. Inputs are sampled on
the rising clock edge, and every output is a register that changes on that
same edge.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mode is 00 (free-run), ref_sel is 0 and both strobes are low.
- R2: In free-run with no reference qualified the mode stays 00, and lock_ok has no effect on it.
- R3: From free-run, as soon as any ref_ok bit (bit n means reference n) is high, the mode becomes 01 (lock acquisition) on the lowest-index qualified reference.
- R4: In lock acquisition, lock_ok high while the selected reference is qualified moves the mode to 10 (normal) on the next edge, keeping ref_sel.
- R5: In normal, if the selected reference loses qualification while another is qualified, the mode becomes 01 on the lowest-index other qualified reference, with no strobe.
- R6: In normal, if the selected reference loses qualification and no other is qualified, the mode becomes 11 (holdover) and freeze_stb is high for exactly that first holdover cycle. Holdover persists while nothing is qualified.
- R7: In holdover, any qualified reference moves the mode to 01 on the lowest-index qualified reference, and release_stb is high for that one cycle.
- R8: In lock acquisition, if the selected reference is lost and none other is qualified, the mode becomes 11 if normal has been reached since reset, otherwise 00.
- R9: With man_en high, the next mode equals man_mode and ref_sel equals man_ref. A man_ref value of 3 or more leaves ref_sel unchanged.
- R10: When man_en falls, the automatic machine resumes from the mode and reference that were last forced.
- R11: freeze_stb and release_stb are never high together. Each marks only a change into or out of holdover, whatever caused the change, including manual forcing.
- R12: While the selected reference stays qualified in lock acquisition, a newly qualified lower-index reference does not change ref_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | NREF (3) | Per-reference qualified flags, bit n for reference n |
| lock_ok | input | 1 | Loop reports phase lock on the selected reference |
| man_en | input | 1 | Manual override enable |
| man_mode | input | 2 | Forced mode: 00 free-run, 01 acquisition, 10 normal, 11 holdover |
| man_ref | input | IDXW (2) | Forced reference index |
| mode | output | 2 | Current mode, same encoding as man_mode |
| ref_sel | output | IDXW (2) | Reference the loop follows |
| freeze_stb | output | 1 | One-cycle pulse on entry into holdover |
| release_stb | output | 1 | One-cycle pulse on exit from holdover |

## Verification
The bench targets the failover fork out of normal mode, where a design that ignores the other references drops into holdover, or one that keeps the failed index locks onto a dead input. It drives lock acquisition with no reference left, both with and without a prior lock, to catch a machine that enters holdover with no frequency history or that returns to free-run after history exists. It also checks strobe width and exclusivity across manual forcing, where a design that only watches the automatic transitions would miss a freeze or release. Finally it checks the hand-back from manual to automatic, where stale internal state would show up as a wrong next mode.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_ACQ  = 2'b01,
    MODE_NORM = 2'b10,
    MODE_HOLD = 2'b11
  } sync_mode_t;
endpackage

// File: rtl/sync_ref_pick.sv
// Lowest-index set bit finder over a reference mask.
module sync_ref_pick #(
  parameter int NREF = 3,
  localparam int IDXW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic [NREF-1:0] mask,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

  always_comb begin
    assert_pick_found_R3: assert (found == (|mask));
  end
endmodule

// File: rtl/sync_mode_fsm.sv
// Mode state register, history flag and next-state decision.
module sync_mode_fsm
  import sync_mode_pkg::*;
#(
  parameter int NREF = 3,
  localparam int IDXW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_ok,
  input  logic            lock_ok,
  input  logic            man_en,
  input  logic [1:0]      man_mode,
  input  logic [IDXW-1:0] man_ref,
  input  logic            any_found,
  input  logic [IDXW-1:0] any_idx,
  input  logic            oth_found,
  input  logic [IDXW-1:0] oth_idx,
  output sync_mode_t      mode_q,
  output sync_mode_t      mode_d,
  output logic [IDXW-1:0] ref_q
);
  logic [IDXW-1:0] ref_d;
  logic            hist_q;
  logic            cur_ok;

  assign cur_ok = ref_ok[ref_q];

  always_comb begin
    mode_d = mode_q;
    ref_d  = ref_q;
    if (man_en) begin
      mode_d = sync_mode_t'(man_mode);
      if (32'(man_ref) < NREF) ref_d = man_ref;
    end else begin
      unique case (mode_q)
        MODE_FREE: begin
          if (any_found) begin
            mode_d = MODE_ACQ;
            ref_d  = any_idx;
          end
        end
        MODE_ACQ: begin
          if (cur_ok) begin
            if (lock_ok) mode_d = MODE_NORM;
          end else if (oth_found) begin
            ref_d = oth_idx;
          end else begin
            mode_d = hist_q ? MODE_HOLD : MODE_FREE;
          end
        end
        MODE_NORM: begin
          if (!cur_ok) begin
            if (oth_found) begin
              mode_d = MODE_ACQ;
              ref_d  = oth_idx;
            end else begin
              mode_d = MODE_HOLD;
            end
          end
        end
        MODE_HOLD: begin
          if (any_found) begin
            mode_d = MODE_ACQ;
            ref_d  = any_idx;
          end
        end
        default: mode_d = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      ref_q  <= '0;
      hist_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ref_q  <= ref_d;
      if (mode_d == MODE_NORM) hist_q <= 1'b1;
    end
  end

  assert_ref_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ref_q) < NREF);

  assert_free_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode_q == MODE_FREE && ref_ok == '0) |=> mode_q == MODE_FREE);

  assert_lock_to_norm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode_q == MODE_ACQ && lock_ok && ref_ok[ref_q])
      |=> (mode_q == MODE_NORM && $stable(ref_q)));

  assert_hold_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode_q == MODE_HOLD && ref_ok != '0) |=> mode_q == MODE_ACQ);

  assert_manual_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    man_en |=> mode_q == sync_mode_t'($past(man_mode)));

  assert_sticky_ref_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && mode_q == MODE_ACQ && ref_ok[ref_q]) |=> $stable(ref_q));
endmodule

// File: rtl/sync_hold_strobe.sv
// Registers freeze/release pulses aligned with the first cycle of the new mode.
module sync_hold_strobe
  import sync_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sync_mode_t mode_q,
  input  sync_mode_t mode_d,
  output logic       freeze_stb,
  output logic       release_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze_stb  <= 1'b0;
      release_stb <= 1'b0;
    end else begin
      freeze_stb  <= (mode_d == MODE_HOLD) && (mode_q != MODE_HOLD);
      release_stb <= (mode_d != MODE_HOLD) && (mode_q == MODE_HOLD);
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(freeze_stb && release_stb));

  assert_freeze_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_stb |-> (mode_q == MODE_HOLD && $past(mode_q) != MODE_HOLD));

  assert_release_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_stb |-> (mode_q != MODE_HOLD && $past(mode_q) == MODE_HOLD));

  assert_freeze_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_stb |=> !freeze_stb);
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int NREF = 3,
  localparam int IDXW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_ok,
  input  logic            lock_ok,
  input  logic            man_en,
  input  logic [1:0]      man_mode,
  input  logic [IDXW-1:0] man_ref,
  output logic [1:0]      mode,
  output logic [IDXW-1:0] ref_sel,
  output logic            freeze_stb,
  output logic            release_stb
);
  sync_mode_t      mode_q, mode_d;
  logic [IDXW-1:0] ref_q;
  logic [NREF-1:0] oth_mask;
  logic            any_found, oth_found;
  logic [IDXW-1:0] any_idx, oth_idx;

  always_comb begin
    oth_mask = ref_ok;
    oth_mask[ref_q] = 1'b0;
  end

  sync_ref_pick #(.NREF(NREF)) any_pick_i (
    .mask(ref_ok), .found(any_found), .idx(any_idx));

  sync_ref_pick #(.NREF(NREF)) oth_pick_i (
    .mask(oth_mask), .found(oth_found), .idx(oth_idx));

  sync_mode_fsm #(.NREF(NREF)) fsm_i (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_ok(lock_ok),
    .man_en(man_en), .man_mode(man_mode), .man_ref(man_ref),
    .any_found(any_found), .any_idx(any_idx),
    .oth_found(oth_found), .oth_idx(oth_idx),
    .mode_q(mode_q), .mode_d(mode_d), .ref_q(ref_q));

  sync_hold_strobe strobe_i (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .mode_d(mode_d),
    .freeze_stb(freeze_stb), .release_stb(release_stb));

  assign mode    = mode_q;
  assign ref_sel = ref_q;
endmodule

// File: tb/sync_mode_ctrl_tb_top.sv
module sync_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ref_ok = '0;
  logic       lock_ok = 1'b0;
  logic       man_en = 1'b0;
  logic [1:0] man_mode = '0;
  logic [1:0] man_ref = '0;
  logic [1:0] mode;
  logic [1:0] ref_sel;
  logic       freeze_stb, release_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sync_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_ok(lock_ok),
    .man_en(man_en), .man_mode(man_mode), .man_ref(man_ref),
    .mode(mode), .ref_sel(ref_sel),
    .freeze_stb(freeze_stb), .release_stb(release_stb));

  typedef struct packed {
    logic [2:0] ok;
    logic       lk;
    logic       me;
    logic [1:0] mm;
    logic [1:0] mr;
    logic [1:0] em;
    logic [1:0] er;
    logic       ef;
    logic       erl;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [0:NV-1] = '{
    '{3'b000, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 lock ignored
    '{3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2
    '{3'b110, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 4'd3},  // R3 lowest is 1
    '{3'b111, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 4'd12}, // R12 sticky
    '{3'b111, 1'b1, 1'b0, 2'd0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd4},  // R4
    '{3'b101, 1'b1, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 failover
    '{3'b101, 1'b1, 1'b0, 2'd0, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 freeze
    '{3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd11}, // R11 one cycle
    '{3'b100, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 4'd7},  // R7 release
    '{3'b100, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 4'd11}, // R11
    '{3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 4'd8},  // R8 history
    '{3'b010, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b1, 4'd7},  // R7
    '{3'b000, 1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 4'd9},  // R9
    '{3'b000, 1'b0, 1'b1, 2'd3, 2'd3, 2'd3, 2'd2, 1'b1, 1'b0, 4'd9},  // R9 idx 3 kept
    '{3'b000, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd11}, // R11 manual exit
    '{3'b001, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd10}, // R10
    '{3'b000, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 1'b0, 1'b0, 4'd9},  // R9
    '{3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd1, 1'b1, 1'b0, 4'd10}  // R10 auto hold
  };

  task automatic check(input string tag, input logic [1:0] em, input logic [1:0] er,
                       input logic ef, input logic erl);
    n_chk++;
    if (mode !== em || ref_sel !== er || freeze_stb !== ef || release_stb !== erl) begin
      n_bad++;
      $display("FAIL %s: got mode=%0d ref=%0d frz=%0b rel=%0b, expected mode=%0d ref=%0d frz=%0b rel=%0b",
               tag, mode, ref_sel, freeze_stb, release_stb, em, er, ef, erl);
    end
  endtask

  task automatic step(input logic [2:0] ok, input logic lk, input logic me,
                      input logic [1:0] mm, input logic [1:0] mr);
    @(negedge clk);
    ref_ok = ok; lock_ok = lk; man_en = me; man_mode = mm; man_ref = mr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 2'd0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(3'b000, 1'b0, 1'b0, 2'd0, 2'd0);
    check("R1 after reset", 2'd0, 2'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ok, VEC[i].lk, VEC[i].me, VEC[i].mm, VEC[i].mr);
      check($sformatf("R%0d row %0d", VEC[i].req, i),
            VEC[i].em, VEC[i].er, VEC[i].ef, VEC[i].erl);
    end

    // R1: reset in the middle of holdover
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", 2'd0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: acquisition lost with no history returns to free-run
    step(3'b100, 1'b0, 1'b0, 2'd0, 2'd0);
    check("R3 after reset", 2'd1, 2'd2, 1'b0, 1'b0);
    step(3'b000, 1'b1, 1'b0, 2'd0, 2'd0);
    check("R8 no history", 2'd0, 2'd2, 1'b0, 1'b0);

    // R5: acquisition on a lost reference moves to another qualified one
    step(3'b001, 1'b0, 1'b0, 2'd0, 2'd0);
    check("R3 ref0", 2'd1, 2'd0, 1'b0, 1'b0);
    step(3'b110, 1'b1, 1'b0, 2'd0, 2'd0);
    check("R5 acq reselect", 2'd1, 2'd1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule